// File: doc/BRIEF.md
# Memory-Mapped I/O Range Router

This block decides where a CPU memory-mapped I/O request goes. It holds a set of programmable address windows. Each window has a base register and a limit register. The windows cover a 40-bit physical address at 64 KB granularity: only address bits 39:16 take part in the compare. For each request the block reports whether a window claimed it and, if one did, the destination node, the destination link, and whether a write has to be treated as non-posted.

Firmware programs the windows through a small register port. Each window carries three controls of its own:
- a lock bit, which freezes both of the window's registers until the next reset;
- a CPU-disable bit, which hides the window from requests that the CPU originated;
- a non-posted flag, which forces CPU writes that hit the window to be reported as non-posted.

A window whose link field holds the reserved code is never selected. Forwarding the transaction, the link protocol and the handling of responses all belong to neighbouring blocks.

Top module: `mmio_range_router`

## Requirements
- R1: After a synchronous reset every window register reads as zero, and no request hits.
- R2: A register is selected by `cfg_addr`, where bit 0 picks base (0) or limit (1) and the upper bits give the window index. Base fields are: bit 0 read enable, bit 1 write enable, bit 2 CPU disable, bit 3 lock, bits 31:8 address bits 39:16 of the window start. Read data appears on `cfg_rdata` one cycle after `cfg_rd`.
- R3: Limit fields are: bits 2:0 destination node, bits 5:4 destination link, bit 7 non-posted, bits 31:8 address bits 39:16 of the window end. Base bits 7:4 and limit bits 3 and 6 always read as zero.
- R4: A window matches when base <= address[39:16] <= limit (both bounds inclusive). A read also needs the read enable set, and a write needs the write enable set.
- R5: When several windows match, the one with the lowest index supplies node and link.
- R6: While a window's lock bit is set, writes to its base and limit registers have no effect. The lock bit is cleared only by reset.
- R7: A request with `req_cpu`=1 never matches a window whose CPU-disable bit is set; the same request with `req_cpu`=0 may match it.
- R8: A window whose link field is 2'b11 never matches.
- R9: `rsp_nonposted` is 1 only for a hit that is a CPU write to a window with the non-posted flag set. Reads, and writes from other sources, report 0.
- R10: Every request produces `rsp_valid` exactly one cycle later. On a miss, `rsp_hit`, `rsp_node`, `rsp_link` and `rsp_nonposted` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | $clog2(NUM_RANGES)+1 | Window index and base/limit select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | PA_W | Physical address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 1 | Request originated by the CPU |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_node | output | 3 | Destination node |
| rsp_link | output | 2 | Destination link |
| rsp_nonposted | output | 1 | Write must be non-posted |

## Verification
The bench probes both inclusive edges of a window and the addresses one 64 KB step outside each edge. A design that used strict compares would drop the end addresses, and one that compared too few bits would claim the neighbours.

It places two windows so that they overlap. A design that resolved the overlap in the wrong order would return the higher window's node.

It locks a window, then writes different values to it and reads them back. A design whose lock guarded only the base register, or that let the lock clear itself, would show the new values.

It runs the same address with the CPU flag set and with it clear, and does the same for the reserved link code. It also mixes read, write and request source against a non-posted window. A wrong qualifier would show up as a spurious hit or as a spurious non-posted report.

// File: rtl/mmio_rr_pkg.sv
package mmio_rr_pkg;
  localparam int unsigned SEG_W  = 24;
  localparam int unsigned NODE_W = 3;
  localparam int unsigned LINK_W = 2;
  localparam int unsigned REG_W  = 32;
  localparam logic [LINK_W-1:0] LINK_RSVD = 2'b11;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic             lock;
    logic             cpu_dis;
    logic             wr_en;
    logic             rd_en;
  } win_base_t;

  typedef struct packed {
    logic [SEG_W-1:0]  seg;
    logic              np;
    logic [LINK_W-1:0] link;
    logic [NODE_W-1:0] node;
  } win_limit_t;

  function automatic logic [REG_W-1:0] base_to_word(input win_base_t b);
    return {b.seg, 4'b0000, b.lock, b.cpu_dis, b.wr_en, b.rd_en};
  endfunction

  function automatic logic [REG_W-1:0] limit_to_word(input win_limit_t l);
    return {l.seg, l.np, 1'b0, l.link, 1'b0, l.node};
  endfunction

  function automatic win_base_t word_to_base(input logic [REG_W-1:0] w);
    win_base_t b;
    b.seg     = w[31:8];
    b.lock    = w[3];
    b.cpu_dis = w[2];
    b.wr_en   = w[1];
    b.rd_en   = w[0];
    return b;
  endfunction

  function automatic win_limit_t word_to_limit(input logic [REG_W-1:0] w);
    win_limit_t l;
    l.seg  = w[31:8];
    l.np   = w[7];
    l.link = w[5:4];
    l.node = w[2:0];
    return l;
  endfunction
endpackage

// File: rtl/mmio_rr_regs.sv
module mmio_rr_regs
  import mmio_rr_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 8,
  localparam int unsigned IDX_W = $clog2(NUM_RANGES)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [IDX_W:0]                    addr,
  input  logic [REG_W-1:0]                  wdata,
  output logic [REG_W-1:0]                  rdata,
  output win_base_t  [NUM_RANGES-1:0]       base_o,
  output win_limit_t [NUM_RANGES-1:0]       limit_o
);
  logic [IDX_W-1:0] sel_idx;
  logic             sel_limit;
  assign sel_idx   = addr[IDX_W:1];
  assign sel_limit = addr[0];

  win_base_t  [NUM_RANGES-1:0] base_q;
  win_limit_t [NUM_RANGES-1:0] limit_q;

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
    logic hit_me;
    assign hit_me = wr_en && (sel_idx == IDX_W'(i)) && !base_q[i].lock;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end else if (hit_me) begin
        if (sel_limit) limit_q[i] <= word_to_limit(wdata);
        else           base_q[i]  <= word_to_base(wdata);
      end
    end

    // R6
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      $past(base_q[i].lock) |-> ($stable(base_q[i]) && $stable(limit_q[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (32'(sel_idx) >= NUM_RANGES) rdata <= '0;
      else if (sel_limit)            rdata <= limit_to_word(limit_q[sel_idx]);
      else                           rdata <= base_to_word(base_q[sel_idx]);
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;

  // R3
  base_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel_limit) |=> (rdata[7:4] == 4'b0000));
  // R3
  limit_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_limit) |=> (rdata[3] == 1'b0 && rdata[6] == 1'b0));
endmodule

// File: rtl/mmio_rr_cmp.sv
module mmio_rr_cmp
  import mmio_rr_pkg::*;
(
  input  win_base_t        base_i,
  input  win_limit_t       limit_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic             write_i,
  input  logic             cpu_i,
  output logic             hit_o
);
  logic above_base, below_limit, access_ok, source_ok, link_ok;

  always_comb begin
    above_base  = seg_i >= base_i.seg;
    below_limit = seg_i <= limit_i.seg;
    access_ok   = write_i ? base_i.wr_en : base_i.rd_en;
    source_ok   = !(cpu_i && base_i.cpu_dis);
    link_ok     = limit_i.link != LINK_RSVD;
    hit_o       = above_base && below_limit && access_ok && source_ok && link_ok;
  end
endmodule

// File: rtl/mmio_rr_pick.sv
module mmio_rr_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hits_i[k]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/mmio_range_router.sv
module mmio_range_router
  import mmio_rr_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 8,
  parameter int unsigned PA_W       = 40,
  parameter int unsigned GRAN_W     = 16,
  localparam int unsigned IDX_W     = $clog2(NUM_RANGES),
  localparam int unsigned CFG_AW    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [PA_W-1:0]   req_addr,
  input  logic              req_write,
  input  logic              req_cpu,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [2:0]        rsp_node,
  output logic [1:0]        rsp_link,
  output logic              rsp_nonposted
);
  win_base_t  [NUM_RANGES-1:0] win_base;
  win_limit_t [NUM_RANGES-1:0] win_limit;
  logic [NUM_RANGES-1:0]       hit_vec;
  logic                        hit_any;
  logic [IDX_W-1:0]            pick;
  logic [SEG_W-1:0]            req_seg;

  assign req_seg = SEG_W'(req_addr[PA_W-1:GRAN_W]);

  mmio_rr_regs #(.NUM_RANGES(NUM_RANGES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .rd_en   (cfg_rd),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .base_o  (win_base),
    .limit_o (win_limit)
  );

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    mmio_rr_cmp u_cmp (
      .base_i  (win_base[i]),
      .limit_i (win_limit[i]),
      .seg_i   (req_seg),
      .write_i (req_write),
      .cpu_i   (req_cpu),
      .hit_o   (hit_vec[i])
    );

    // R7
    cpu_hidden_chk: assert property (@(posedge clk) disable iff (rst)
      (req_cpu && win_base[i].cpu_dis) |-> !hit_vec[i]);
  end

  mmio_rr_pick #(.N(NUM_RANGES)) u_pick (
    .hits_i (hit_vec),
    .any_o  (hit_any),
    .idx_o  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_node      <= '0;
      rsp_link      <= '0;
      rsp_nonposted <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid && hit_any) begin
        rsp_hit       <= 1'b1;
        rsp_node      <= win_limit[pick].node;
        rsp_link      <= win_limit[pick].link;
        rsp_nonposted <= req_write && req_cpu && win_limit[pick].np;
      end else begin
        rsp_hit       <= 1'b0;
        rsp_node      <= '0;
        rsp_link      <= '0;
        rsp_nonposted <= 1'b0;
      end
    end
  end

  logic [NUM_RANGES-1:0] below_pick;
  assign below_pick = (NUM_RANGES'(1) << pick) - NUM_RANGES'(1);

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (hit_vec[pick] && ((hit_vec & below_pick) == '0)));
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_hit));
  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_node == '0 && rsp_link == '0 && !rsp_nonposted));
  // R9
  np_cpu_write_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_nonposted |-> (rsp_hit && $past(req_write) && $past(req_cpu)));
  // R8
  no_rsvd_link_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_link != LINK_RSVD));
endmodule

// File: tb/mmio_range_router_tb.sv
`timescale 1ns/1ps
module mmio_range_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0, req_cpu = 1'b0;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_nonposted;
  logic [2:0]  rsp_node;
  logic [1:0]  rsp_link;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmio_range_router u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_node(rsp_node),
    .rsp_link(rsp_link), .rsp_nonposted(rsp_nonposted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_base(input logic [23:0] seg, input bit lk, input bit cd,
                                          input bit we, input bit re);
    return {seg, 4'b0, lk, cd, we, re};
  endfunction

  function automatic logic [31:0] mk_lim(input logic [23:0] seg, input bit np,
                                         input logic [1:0] lnk, input logic [2:0] nd);
    return {seg, np, 1'b0, lnk, 1'b0, nd};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input int win, input bit lim, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = {3'(win), lim}; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int win, input bit lim, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = {3'(win), lim};
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic send(input logic [23:0] seg, input logic [15:0] off, input bit w, input bit c);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {seg, off}; req_write = w; req_cpu = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input bit h, input logic [2:0] n,
                            input logic [1:0] l, input bit np);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " hit"},   32'(rsp_hit),   32'(h));
    chk({tag, " node"},  32'(rsp_node),  32'(n));
    chk({tag, " link"},  32'(rsp_link),  32'(l));
    chk({tag, " np"},    32'(rsp_nonposted), 32'(np));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      for (int s = 0; s < 2; s++) begin
        rd_reg(w, s[0], d);
        chk("R1 reset readback", d, 32'h0);
      end
    end
    send(24'h0, 16'h0, 1'b0, 1'b1);
    expect_rsp("R1 R10 reset miss", 0, 0, 0, 0);
    @(negedge clk);
    chk("R10 idle no valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr_reg(7, 0, 32'hFFFF_FFF7);
    rd_reg(7, 0, d);
    chk("R2 R3 base fields", d, 32'hFFFF_FF07);
    wr_reg(7, 1, 32'hFFFF_FFFF);
    rd_reg(7, 1, d);
    chk("R3 limit fields", d, 32'hFFFF_FFB7);
    wr_reg(7, 0, 32'h0);
    wr_reg(7, 1, 32'h0);
    rd_reg(7, 0, d);
    chk("R2 base cleared", d, 32'h0);
  endtask

  task automatic t_match();
    wr_reg(2, 1, mk_lim(24'h0001FF, 0, 2'd2, 3'd5));
    wr_reg(2, 0, mk_base(24'h000100, 0, 0, 1, 1));
    send(24'h000100, 16'h0000, 0, 1); expect_rsp("R4 low edge", 1, 5, 2, 0);
    send(24'h0001FF, 16'hFFFF, 0, 1); expect_rsp("R4 high edge", 1, 5, 2, 0);
    send(24'h000200, 16'h0000, 0, 1); expect_rsp("R4 above", 0, 0, 0, 0);
    send(24'h0000FF, 16'hFFFF, 0, 1); expect_rsp("R4 below", 0, 0, 0, 0);
    wr_reg(3, 1, mk_lim(24'h000300, 0, 2'd1, 3'd1));
    wr_reg(3, 0, mk_base(24'h000300, 0, 0, 0, 1));
    send(24'h000300, 16'h1234, 0, 0); expect_rsp("R4 read allowed", 1, 1, 1, 0);
    send(24'h000300, 16'h1234, 1, 0); expect_rsp("R4 write blocked", 0, 0, 0, 0);
  endtask

  task automatic t_prio();
    wr_reg(1, 1, mk_lim(24'h000180, 0, 2'd0, 3'd3));
    wr_reg(1, 0, mk_base(24'h000180, 0, 0, 1, 1));
    send(24'h000180, 16'h0, 1, 0); expect_rsp("R5 overlap low index", 1, 3, 0, 0);
    send(24'h000190, 16'h0, 1, 0); expect_rsp("R5 only upper window", 1, 5, 2, 0);
  endtask

  task automatic t_cpu();
    wr_reg(4, 1, mk_lim(24'h000400, 0, 2'd1, 3'd6));
    wr_reg(4, 0, mk_base(24'h000400, 0, 1, 1, 1));
    send(24'h000400, 16'h0, 0, 1); expect_rsp("R7 cpu hidden", 0, 0, 0, 0);
    send(24'h000400, 16'h0, 0, 0); expect_rsp("R7 non-cpu sees", 1, 6, 1, 0);
  endtask

  task automatic t_link();
    wr_reg(5, 1, mk_lim(24'h000500, 0, 2'd3, 3'd7));
    wr_reg(5, 0, mk_base(24'h000500, 0, 0, 1, 1));
    send(24'h000500, 16'h0, 0, 0); expect_rsp("R8 reserved link", 0, 0, 0, 0);
    wr_reg(5, 1, mk_lim(24'h000500, 0, 2'd0, 3'd7));
    send(24'h000500, 16'h0, 0, 0); expect_rsp("R8 valid link", 1, 7, 0, 0);
  endtask

  task automatic t_np();
    wr_reg(6, 1, mk_lim(24'h000600, 1, 2'd0, 3'd2));
    wr_reg(6, 0, mk_base(24'h000600, 0, 0, 1, 1));
    send(24'h000600, 16'h0, 1, 1); expect_rsp("R9 cpu write np", 1, 2, 0, 1);
    send(24'h000600, 16'h0, 0, 1); expect_rsp("R9 cpu read", 1, 2, 0, 0);
    send(24'h000600, 16'h0, 1, 0); expect_rsp("R9 non-cpu write", 1, 2, 0, 0);
    send(24'h000100, 16'h0, 1, 1); expect_rsp("R9 flag clear", 1, 5, 2, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr_reg(0, 1, mk_lim(24'h000700, 0, 2'd1, 3'd4));
    wr_reg(0, 0, mk_base(24'h000700, 1, 0, 1, 1));
    wr_reg(0, 0, 32'h0);
    wr_reg(0, 1, 32'h0);
    rd_reg(0, 0, d); chk("R6 base frozen", d, mk_base(24'h000700, 1, 0, 1, 1));
    rd_reg(0, 1, d); chk("R6 limit frozen", d, mk_lim(24'h000700, 0, 2'd1, 3'd4));
    send(24'h000700, 16'h0, 1, 1); expect_rsp("R6 locked window routes", 1, 4, 1, 0);
    do_reset();
    rd_reg(0, 0, d); chk("R6 R1 reset clears lock", d, 32'h0);
    wr_reg(0, 0, mk_base(24'h000010, 0, 0, 0, 1));
    rd_reg(0, 0, d); chk("R6 writable after reset", d, mk_base(24'h000010, 0, 0, 0, 1));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    t_reset();
    t_fields();
    t_match();
    t_prio();
    t_cpu();
    t_link();
    t_np();
    t_lock();
    finish_up();
  end
endmodule